// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Controller

This block holds the interrupt request and priority logic for one peripheral in a serial priority chain. The peripheral has eight internal status bits, and each bit has a mask bit. A source with both bits set can pull the active-low request line to the CPU. The CPU answers with an active-low acknowledge strobe. The controller reacts to the falling edge of that strobe and marks its interrupt as in service.

In chained mode, the controller takes an enable from the next higher-priority device and passes an enable to the next lower-priority device. The incoming enable acts as a global gate on requests, overriding the mask. The outgoing enable goes low while a request is pending and stays low while an interrupt is in service. It returns high only after software issues the end-of-service strobe. The highest-priority device has its incoming enable tied high. In direct mode, the incoming enable does not gate requests and is passed straight through.

All interfaces are plain control pins, so there is no valid/ready stream and no back-pressure.

Top module: `irq_chain_ctrl`

## Requirements
- R1: Source i is eligible when `src_stat[i]` and mask bit i are both 1. When at least one source is eligible, the gate is open and nothing is in service, `irq_n` goes low on the next rising clock edge. When no source is eligible, `irq_n` is high after the next edge.
- R2: When `mask_we` is 1 on a clock edge, the mask register loads `mask_wdata` (bit i masks source i, and 1 enables it). While `mask_we` is 0 the register holds its value.
- R3: When `chain_mode` is 1 and `chain_en_in` is 0, `irq_n` is high after the next edge, whatever the status and mask bits are.
- R4: When `chain_mode` is 1, `chain_en_out` equals `chain_en_in` AND `irq_n` AND (no interrupt in service). It is therefore low in every cycle in which `irq_n` is low.
- R5: An acknowledge is a sampled `iack_n` of 0 when the previous sample was 1. If an acknowledge arrives while `irq_n` is low and the gate is open, the interrupt enters service on that edge, and `irq_n` is high after it.
- R6: While an interrupt is in service, `irq_n` stays high whatever the status bits do, and in chained mode `chain_en_out` stays low.
- R7: A one-cycle `svc_done` strobe ends service on the next edge. If `svc_done` coincides with an acknowledge, the acknowledge is discarded, and `svc_done` takes priority.
- R8: When `chain_mode` is 0, `chain_en_in` does not gate requests, and `chain_en_out` equals `chain_en_in` in every cycle.
- R9: A synchronous `rst` of 1 clears the mask and the in-service state and drives `irq_n` high.
- R10: An acknowledge edge that arrives while `irq_n` is high does not start service, and a later eligible source still raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_stat | input | 8 | Interrupt status bits, one per source |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 8 | New mask value |
| chain_mode | input | 1 | 1 = chained priority operation, 0 = direct |
| chain_en_in | input | 1 | Enable from the higher-priority neighbour |
| iack_n | input | 1 | CPU acknowledge strobe, active low |
| svc_done | input | 1 | End-of-service command strobe |
| irq_n | output | 1 | Registered interrupt request, active low |
| chain_en_out | output | 1 | Enable to the lower-priority neighbour |

## Verification
A wrong mask bit or a wrong eligibility term shows up one edge later as a wrong `irq_n` level for that status pattern. The bench finds it by sweeping every mask value against many status patterns, in both modes and at both gate levels. A stuck or missing in-service state shows up within a cycle or two after an acknowledge or after `svc_done`. The symptom is either `chain_en_out` failing to stay low, or a request that is not blocked or not re-armed. `chain_en_out` is combinational, so a wrong chain term is visible in the same cycle in which its inputs change.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int unsigned SRC_COUNT = 8;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_CHAIN  = 1'b1
  } chain_mode_e;

  function automatic logic gate_for(input chain_mode_e mode, input logic en_in);
    return (mode == MODE_CHAIN) ? en_in : 1'b1;
  endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_data,
  input  logic [NSRC-1:0] stat,
  output logic            any_hit
);
  logic [NSRC-1:0] mask_q;
  logic [NSRC-1:0] hit;

  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wr_data;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = stat[i] & mask_q[i];
  end

  assign any_hit = |hit;
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic clk,
  input  logic rst,
  input  logic ack_n,
  input  logic req_live,
  input  logic gate_open,
  input  logic done,
  output logic in_svc,
  output logic take
);
  logic ack_prev;
  logic ack_edge;

  always_ff @(posedge clk) begin
    if (rst) ack_prev <= 1'b1;
    else     ack_prev <= ack_n;
  end

  assign ack_edge = ack_prev & ~ack_n;
  // done has priority over a simultaneous acknowledge
  assign take = ack_edge & req_live & gate_open & ~done;

  always_ff @(posedge clk) begin
    if (rst)       in_svc <= 1'b0;
    else if (done) in_svc <= 1'b0;
    else if (take) in_svc <= 1'b1;
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic any_hit,
  input  logic gate_open,
  input  logic in_svc,
  input  logic take,
  output logic req_n
);
  logic raise;

  assign raise = any_hit & gate_open & ~in_svc & ~take;

  always_ff @(posedge clk) begin
    if (rst) req_n <= 1'b1;
    else     req_n <= ~raise;
  end
endmodule

// File: rtl/irq_chain_pass.sv
module irq_chain_pass
  import irq_chain_pkg::*;
(
  input  chain_mode_e mode,
  input  logic        en_in,
  input  logic        req_n,
  input  logic        in_svc,
  output logic        en_out,
  output logic        gate_open
);
  assign gate_open = gate_for(mode, en_in);

  always_comb begin
    if (mode == MODE_CHAIN) en_out = en_in & req_n & ~in_svc;
    else                    en_out = en_in;
  end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
#(
  parameter int unsigned NSRC = SRC_COUNT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_stat,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            chain_mode,
  input  logic            chain_en_in,
  input  logic            iack_n,
  input  logic            svc_done,
  output logic            irq_n,
  output logic            chain_en_out
);
  chain_mode_e mode;
  logic any_hit, gate_open, in_svc, take;

  assign mode = chain_mode_e'(chain_mode);

  irq_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst(rst), .wr_en(mask_we), .wr_data(mask_wdata),
    .stat(src_stat), .any_hit(any_hit)
  );

  irq_svc_track u_svc (
    .clk(clk), .rst(rst), .ack_n(iack_n), .req_live(~irq_n),
    .gate_open(gate_open), .done(svc_done), .in_svc(in_svc), .take(take)
  );

  irq_req_gen u_req (
    .clk(clk), .rst(rst), .any_hit(any_hit), .gate_open(gate_open),
    .in_svc(in_svc), .take(take), .req_n(irq_n)
  );

  irq_chain_pass u_pass (
    .mode(mode), .en_in(chain_en_in), .req_n(irq_n), .in_svc(in_svc),
    .en_out(chain_en_out), .gate_open(gate_open)
  );
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int unsigned NSRC = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] src_stat,
  input logic            chain_mode,
  input logic            chain_en_in,
  input logic            iack_n,
  input logic            svc_done,
  input logic            irq_n,
  input logic            chain_en_out
);
  AST_QUIET_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
    (src_stat == '0) |=> irq_n); // R1
  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (chain_mode && !chain_en_in) |=> irq_n); // R3
  AST_REQ_BLOCKS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    (chain_mode && !irq_n) |-> !chain_en_out); // R4
  AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(iack_n) && !irq_n && (chain_en_in || !chain_mode) && !svc_done) |=> irq_n); // R5
  AST_SVC_HOLDS_CHAIN: assert property (@(posedge clk) disable iff (rst)
    ($fell(iack_n) && !irq_n && chain_en_in && chain_mode && !svc_done) |=>
      (chain_mode -> !chain_en_out)); // R6
  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    !chain_mode |-> (chain_en_out == chain_en_in)); // R8
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> irq_n); // R9
endmodule

bind irq_chain_ctrl irq_chain_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .src_stat(src_stat), .chain_mode(chain_mode),
  .chain_en_in(chain_en_in), .iack_n(iack_n), .svc_done(svc_done),
  .irq_n(irq_n), .chain_en_out(chain_en_out)
);

// File: tb/tb_irq_chain_ctrl.sv
module tb_irq_chain_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst, mask_we, chain_mode, chain_en_in, iack_n, svc_done;
  logic [N-1:0] src_stat, mask_wdata;
  logic irq_n, chain_en_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_chain_ctrl #(.NSRC(N)) dut (
    .clk(clk), .rst(rst), .src_stat(src_stat), .mask_we(mask_we),
    .mask_wdata(mask_wdata), .chain_mode(chain_mode), .chain_en_in(chain_en_in),
    .iack_n(iack_n), .svc_done(svc_done), .irq_n(irq_n), .chain_en_out(chain_en_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic load_mask(input logic [N-1:0] m);
    mask_we = 1'b1; mask_wdata = m;
    step();
    mask_we = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mask_we = 1'b0; mask_wdata = '0; src_stat = '0;
    chain_mode = 1'b1; chain_en_in = 1'b1; iack_n = 1'b1; svc_done = 1'b0;
    @(negedge clk);
    step();
    rst = 1'b0;
    // R9 reset state
    check("R9 irq_n after reset", irq_n, 1'b1);
    check("R9 chain_en_out after reset", chain_en_out, 1'b1);

    // R1 R2 R3 R4 R8: sweep all masks against status patterns, modes and gate levels
    for (int m = 0; m < 256; m++) begin
      load_mask(m[N-1:0]);
      for (int s = 0; s < 256; s += 17) begin
        for (int c = 0; c < 4; c++) begin
          logic hit, gate, exp_irq;
          src_stat = s[N-1:0];
          chain_mode = c[1];
          chain_en_in = c[0];
          step();
          hit = |(s[N-1:0] & m[N-1:0]);
          gate = chain_mode ? chain_en_in : 1'b1;
          exp_irq = ~(hit & gate);
          check(chain_mode ? (chain_en_in ? "R1 R2 irq_n chained" : "R3 irq_n gate closed")
                           : "R8 irq_n direct", irq_n, exp_irq);
          check(chain_mode ? "R4 chain_en_out" : "R8 chain_en_out pass",
                chain_en_out, chain_mode ? (chain_en_in & exp_irq) : chain_en_in);
        end
      end
    end

    // R2 hold: mask holds while mask_we is 0
    chain_mode = 1'b1; chain_en_in = 1'b1; src_stat = '0;
    load_mask(8'h10);
    mask_wdata = 8'hEF;
    src_stat = 8'h10;
    step();
    check("R2 mask held without write", irq_n, 1'b0);

    // R5 acknowledge enters service
    iack_n = 1'b0;
    step();
    check("R5 irq_n released on ack", irq_n, 1'b1);
    check("R6 chain_en_out low in service", chain_en_out, 1'b0);
    iack_n = 1'b1;
    step();
    check("R6 request blocked in service", irq_n, 1'b1);
    src_stat = '0;
    step();
    check("R6 chain_en_out low after status clears", chain_en_out, 1'b0);
    src_stat = 8'h10;
    step();
    check("R6 no new request in service", irq_n, 1'b1);
    src_stat = '0;
    step();

    // R7 end of service
    svc_done = 1'b1;
    step();
    svc_done = 1'b0;
    check("R7 chain_en_out back high", chain_en_out, 1'b1);
    src_stat = 8'h10;
    step();
    check("R7 request re-armed", irq_n, 1'b0);

    // R7 svc_done wins over simultaneous ack
    iack_n = 1'b0; svc_done = 1'b1;
    step();
    iack_n = 1'b1; svc_done = 1'b0;
    check("R7 ack discarded by svc_done", irq_n, 1'b0);
    src_stat = '0;
    step();
    check("R7 not in service after collision", chain_en_out, 1'b1);

    // R10 ack while no request is ignored
    iack_n = 1'b0;
    step();
    iack_n = 1'b1;
    step();
    src_stat = 8'h10;
    step();
    check("R10 ack without request ignored", irq_n, 1'b0);
    check("R10 chain_en_out low with request", chain_en_out, 1'b0);

    // R8 direct mode: gate ignored, pass-through immediate
    chain_mode = 1'b0; chain_en_in = 1'b0;
    step();
    check("R8 request with enable low", irq_n, 1'b0);
    check("R8 pass low", chain_en_out, 1'b0);
    chain_en_in = 1'b1;
    #1;
    check("R8 pass high immediately", chain_en_out, 1'b1);

    // R5 in direct mode, then R9 reset mid-service
    @(negedge clk);
    iack_n = 1'b0;
    step();
    iack_n = 1'b1;
    check("R5 direct mode ack", irq_n, 1'b1);
    chain_mode = 1'b1;
    #1;
    check("R6 in service seen in chain mode", chain_en_out, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    step();
    rst = 1'b0;
    check("R9 reset clears service", chain_en_out, 1'b1);
    step();
    check("R9 reset clears mask", irq_n, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule